// File: doc/BRIEF.md
# Transmit Descriptor Fetch Engine

This block walks a chain of transmit buffer descriptors held in a word-addressed memory and turns each one into a byte stream for a MAC. Every descriptor is eight 32-bit little-endian words. The engine reads the six words it needs, checks that it owns the descriptor, and fetches the referenced buffer one word at a time. It sends the bytes in ascending address order on a byte-wide valid/ready link, together with start/end markers and the per-frame pad and CRC requests. It then waits for the MAC's completion report and writes a single status word back into the descriptor, which hands the descriptor back to software.

A host loads the byte address of the first descriptor into a pointer register and then kicks the engine by writing the second pointer register with bit 31 set. The engine follows the chain through each descriptor's next-address words until it finds a descriptor whose next-high word has bit 31 set. It stops early on any descriptor whose owner bit is clear.

Top module: `txdesc_fetch_engine`

## Requirements
- R1: After reset the engine issues no memory request and presents no byte (mem_req and tx_valid low).
- R2: A host write with host_wr_sel=0 loads the descriptor byte address; a write with host_wr_sel=1 and data bit 31 set starts the engine, which reads descriptor words 0 to 5 at word address (pointer>>2)+k in ascending order. A host_wr_sel=1 write with bit 31 clear starts nothing.
- R3: If bit 31 (owner) of descriptor word 5 is clear, the engine sends no byte, writes nothing back and goes idle.
- R4: The frame length is bits 15:0 of word 4 and the buffer byte address is word 0. Byte address a is taken from bits 8*(a mod 4)+7 : 8*(a mod 4) of memory word a>>2, and bytes leave in ascending address order. Each buffer word is read once, and unaligned starts are allowed.
- R5: tx_first is high on the first byte only if word 5 bit 1 is set, and tx_last is high on the final byte only if word 5 bit 0 is set. tx_pad follows word 5 bit 4 and tx_crc follows word 5 bit 5 on every byte.
- R6: While tx_valid is high and tx_ready low, the byte and its flags stay unchanged. A memory request holds its address and write enable until mem_ack.
- R7: The write-back is a single write to word 5. It has bit 31 clear and bits 15:0 copied from the fetched word 5. The MAC report goes into bits 19:16 (retry count), 20 (one collision), 24 (late collision), 25 (underrun) and 26 (retry limit). Bit 30 is set exactly when bits 24 to 26 are all clear, and all other bits are zero.
- R8: For a frame of one or more bytes, the write-back happens only after a mac_stat_valid pulse that follows the final byte. Between the final byte and that pulse, the engine neither requests memory nor presents a byte.
- R9: After the write-back, if bit 31 of the next-high word is clear, the engine fetches the descriptor at the byte address in the next-low word; otherwise it goes idle.
- R10: A descriptor with zero length sends no byte, does not wait for the MAC, and is written back with bit 30 set and all report fields zero.
- R11: A kick that arrives while the engine is busy is ignored: the running chain continues unchanged and no extra descriptor is fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_wr_sel | input | 1 | 0: pointer low (byte address), 1: pointer high (bit 31 = start) |
| host_wr_data | input | 32 | Host write data |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access complete; read data valid |
| mem_rdata | input | 32 | Memory read data |
| tx_valid | output | 1 | Byte available |
| tx_ready | input | 1 | MAC accepts byte |
| tx_data | output | 8 | Frame byte |
| tx_first | output | 1 | Start-of-frame marker |
| tx_last | output | 1 | End-of-frame marker |
| tx_pad | output | 1 | Pad request for this frame |
| tx_crc | output | 1 | CRC append request for this frame |
| mac_stat_valid | input | 1 | MAC completion report pulse |
| mac_retry_cnt | input | 4 | Retries used |
| mac_one_coll | input | 1 | Exactly one collision seen |
| mac_late_coll | input | 1 | Late collision |
| mac_underrun | input | 1 | Transmit underrun |
| mac_retry_limit | input | 1 | Retry limit reached |

## Verification
The hardest situation to reach is a kick that arrives in the middle of a chain while the MAC is applying backpressure and memory replies come with irregular latency. In that case a wrong design would restart from the new pointer or fetch one descriptor too many. The stimulus builds a three-descriptor chain: a frame with an unaligned buffer, a zero-length descriptor, and a descriptor the engine does not own. Partway through the first frame it rewrites the pointer to a valid descriptor and kicks again. Ready is pulsed in a duty pattern and memory latency cycles through zero to three wait cycles. Every memory access and byte is compared on its handshake clock against a behavioural walk of the same memory image.

// File: rtl/txd_pkg.sv
package txd_pkg;

  localparam int CFG_EOF  = 0;
  localparam int CFG_SOF  = 1;
  localparam int CFG_PAD  = 4;
  localparam int CFG_CRC  = 5;
  localparam int CFG_OK   = 30;
  localparam int CFG_OWN  = 31;
  localparam int NXT_LAST = 31;
  localparam int KICK_BIT = 31;

  // descriptor word indices the engine consumes
  localparam logic [2:0] W_BUF = 3'd0;
  localparam logic [2:0] W_NLO = 3'd2;
  localparam logic [2:0] W_NHI = 3'd3;
  localparam logic [2:0] W_LEN = 3'd4;
  localparam logic [2:0] W_CFG = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DESC,
    ST_EVAL,
    ST_BUF,
    ST_SEND,
    ST_MAC,
    ST_WB
  } txd_state_e;

  typedef struct packed {
    logic       retry_lim;
    logic       underrun;
    logic       late_coll;
    logic       one_coll;
    logic [3:0] retry;
  } txd_stat_t;

  function automatic logic [7:0] lane_byte(input logic [31:0] w, input logic [1:0] lane);
    return w[{lane, 3'b000} +: 8];
  endfunction

  function automatic logic stat_clean(input txd_stat_t s);
    return !(s.retry_lim || s.underrun || s.late_coll);
  endfunction

  function automatic logic [31:0] wb_word(input logic [15:0] cfg_lo, input txd_stat_t s);
    logic [31:0] r;
    r          = '0;
    r[15:0]    = cfg_lo;
    r[19:16]   = s.retry;
    r[20]      = s.one_coll;
    r[24]      = s.late_coll;
    r[25]      = s.underrun;
    r[26]      = s.retry_lim;
    r[CFG_OK]  = stat_clean(s);
    r[CFG_OWN] = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/txd_ptr_regs.sv
module txd_ptr_regs import txd_pkg::*; #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [31:0]   wr_data,
  output logic [AW+1:0] ptr_byte,
  output logic          kick
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               ptr_byte <= '0;
    else if (wr_en && !wr_sel) ptr_byte <= wr_data[AW+1:0];
  end

  assign kick = wr_en && wr_sel && wr_data[KICK_BIT];

  logic unused_hi_bits;
  assign unused_hi_bits = ^wr_data[30:AW+2];

endmodule

// File: rtl/txd_desc_store.sv
module txd_desc_store import txd_pkg::*; #(
  parameter int AW = 10,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [2:0]    idx,
  input  logic [31:0]   word,
  output logic [AW+1:0] buf_byte,
  output logic [AW-4:0] next_base,
  output logic          next_last,
  output logic [LW-1:0] len,
  output logic [15:0]   cfg_lo,
  output logic          own
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_byte  <= '0;
      next_base <= '0;
      next_last <= 1'b0;
      len       <= '0;
      cfg_lo    <= '0;
      own       <= 1'b0;
    end else if (cap) begin
      case (idx)
        W_BUF: buf_byte  <= word[AW+1:0];
        W_NLO: next_base <= word[AW+1:5];
        W_NHI: next_last <= word[NXT_LAST];
        W_LEN: len       <= word[LW-1:0];
        W_CFG: begin
          cfg_lo <= word[15:0];
          own    <= word[CFG_OWN];
        end
        default: ;
      endcase
    end
  end

  logic unused_word_bits;
  assign unused_word_bits = ^word[30:16];

endmodule

// File: rtl/txd_byte_walker.sv
module txd_byte_walker #(
  parameter int AW = 10,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW+1:0] start_byte,
  input  logic [LW-1:0] count,
  output logic [AW-1:0] word_addr,
  output logic [1:0]    lane,
  output logic          first,
  output logic          last,
  output logic          word_end
);

  logic [AW+1:0] ptr_q;
  logic [LW-1:0] rem_q;
  logic          first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      rem_q   <= '0;
      first_q <= 1'b0;
    end else if (load) begin
      ptr_q   <= start_byte;
      rem_q   <= count;
      first_q <= 1'b1;
    end else if (step) begin
      ptr_q   <= ptr_q + 1'b1;
      rem_q   <= rem_q - 1'b1;
      first_q <= 1'b0;
    end
  end

  assign word_addr = ptr_q[AW+1:2];
  assign lane      = ptr_q[1:0];
  assign first     = first_q;
  assign last      = (rem_q == LW'(1));
  assign word_end  = (ptr_q[1:0] == 2'b11);

endmodule

// File: rtl/txdesc_fetch_engine.sv
module txdesc_fetch_engine import txd_pkg::*; #(
  parameter int AW = 10,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr_en,
  input  logic          host_wr_sel,
  input  logic [31:0]   host_wr_data,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_first,
  output logic          tx_last,
  output logic          tx_pad,
  output logic          tx_crc,
  input  logic          mac_stat_valid,
  input  logic [3:0]    mac_retry_cnt,
  input  logic          mac_one_coll,
  input  logic          mac_late_coll,
  input  logic          mac_underrun,
  input  logic          mac_retry_limit
);

  localparam int BASE_W = AW - 3;
  localparam logic [2:0] LAST_IDX = W_CFG;

  txd_state_e        st;
  logic [2:0]        idx;
  logic [BASE_W-1:0] base;
  logic [31:0]       cur_word;
  txd_stat_t         stat_q;

  logic [AW+1:0]     ptr_byte;
  logic              kick;
  logic [AW+1:0]     buf_byte;
  logic [BASE_W-1:0] next_base;
  logic              next_last;
  logic [LW-1:0]     len;
  logic [15:0]       cfg_lo;
  logic              own;
  logic [AW-1:0]     w_addr;
  logic [1:0]        w_lane;
  logic              w_first, w_last, w_end;

  // named internal events
  logic ev_kick, ev_desc_cap, ev_owner_reject, ev_walk_load;
  logic ev_byte_xfer, ev_last_byte, ev_wb_done;

  assign ev_kick         = (st == ST_IDLE) && kick;
  assign ev_desc_cap     = (st == ST_DESC) && mem_ack;
  assign ev_owner_reject = (st == ST_EVAL) && !own;
  assign ev_walk_load    = (st == ST_EVAL) && own && (len != '0);
  assign ev_byte_xfer    = (st == ST_SEND) && tx_ready;
  assign ev_last_byte    = ev_byte_xfer && w_last;
  assign ev_wb_done      = (st == ST_WB) && mem_ack;

  txd_ptr_regs #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .wr_en(host_wr_en), .wr_sel(host_wr_sel), .wr_data(host_wr_data),
    .ptr_byte(ptr_byte), .kick(kick)
  );

  txd_desc_store #(.AW(AW), .LW(LW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .cap(ev_desc_cap), .idx(idx), .word(mem_rdata),
    .buf_byte(buf_byte), .next_base(next_base), .next_last(next_last),
    .len(len), .cfg_lo(cfg_lo), .own(own)
  );

  txd_byte_walker #(.AW(AW), .LW(LW)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .load(ev_walk_load), .step(ev_byte_xfer),
    .start_byte(buf_byte), .count(len),
    .word_addr(w_addr), .lane(w_lane),
    .first(w_first), .last(w_last), .word_end(w_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      idx      <= '0;
      base     <= '0;
      cur_word <= '0;
      stat_q   <= '0;
    end else begin
      case (st)
        ST_IDLE: if (ev_kick) begin
          base <= ptr_byte[AW+1:5];
          idx  <= '0;
          st   <= ST_DESC;
        end
        ST_DESC: if (mem_ack) begin
          if (idx == LAST_IDX) st <= ST_EVAL;
          else                 idx <= idx + 1'b1;
        end
        ST_EVAL: begin
          if (!own) begin
            st <= ST_IDLE;
          end else if (len == '0) begin
            stat_q <= '0;
            st     <= ST_WB;
          end else begin
            st <= ST_BUF;
          end
        end
        ST_BUF: if (mem_ack) begin
          cur_word <= mem_rdata;
          st       <= ST_SEND;
        end
        ST_SEND: if (tx_ready) begin
          if (w_last)     st <= ST_MAC;
          else if (w_end) st <= ST_BUF;
        end
        ST_MAC: if (mac_stat_valid) begin
          stat_q.retry_lim <= mac_retry_limit;
          stat_q.underrun  <= mac_underrun;
          stat_q.late_coll <= mac_late_coll;
          stat_q.one_coll  <= mac_one_coll;
          stat_q.retry     <= mac_retry_cnt;
          st               <= ST_WB;
        end
        ST_WB: if (mem_ack) begin
          if (next_last) begin
            st <= ST_IDLE;
          end else begin
            base <= next_base;
            idx  <= '0;
            st   <= ST_DESC;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req  = (st == ST_DESC) || (st == ST_BUF) || (st == ST_WB);
    mem_we   = (st == ST_WB);
    case (st)
      ST_DESC: mem_addr = {base, idx};
      ST_BUF:  mem_addr = w_addr;
      ST_WB:   mem_addr = {base, W_CFG};
      default: mem_addr = '0;
    endcase
    mem_wdata = wb_word(cfg_lo, stat_q);
  end

  assign tx_valid = (st == ST_SEND);
  assign tx_data  = lane_byte(cur_word, w_lane);
  assign tx_first = tx_valid && w_first && cfg_lo[CFG_SOF];
  assign tx_last  = tx_valid && w_last && cfg_lo[CFG_EOF];
  assign tx_pad   = tx_valid && cfg_lo[CFG_PAD];
  assign tx_crc   = tx_valid && cfg_lo[CFG_CRC];

endmodule

// File: rtl/txd_engine_chk.sv
module txd_engine_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          tx_first,
  input logic          tx_last,
  input logic          ev_last_byte,
  input logic          ev_owner_reject
);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!mem_req && !tx_valid));

  assert_owner_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_owner_reject |=> (!mem_req && !tx_valid));

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_byte_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_first) && $stable(tx_last)));

  assert_wb_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !mem_wdata[31]);

  assert_wb_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata[30] == !(|mem_wdata[26:24])));

  assert_mac_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_last_byte |=> (!tx_valid && !mem_req));

  assert_port_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && mem_req));

endmodule

bind txdesc_fetch_engine txd_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .tx_first(tx_first), .tx_last(tx_last),
  .ev_last_byte(ev_last_byte), .ev_owner_reject(ev_owner_reject)
);

// File: tb/txdesc_fetch_engine_bench.sv
module txdesc_fetch_engine_bench;
  localparam int AW = 10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          host_wr_en = 1'b0, host_wr_sel = 1'b0;
  logic [31:0]   host_wr_data = '0;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic          mem_ack = 1'b0;
  logic [31:0]   mem_rdata = '0;
  logic          tx_valid, tx_first, tx_last, tx_pad, tx_crc;
  logic          tx_ready = 1'b0;
  logic [7:0]    tx_data;
  logic          mac_stat_valid = 1'b0;
  logic [3:0]    mac_retry_cnt = '0;
  logic          mac_one_coll = 1'b0, mac_late_coll = 1'b0;
  logic          mac_underrun = 1'b0, mac_retry_limit = 1'b0;

  txdesc_fetch_engine #(.AW(AW), .LW(16)) u_txdesc_fetch_engine (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_wr_sel(host_wr_sel), .host_wr_data(host_wr_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_first(tx_first), .tx_last(tx_last), .tx_pad(tx_pad), .tx_crc(tx_crc),
    .mac_stat_valid(mac_stat_valid), .mac_retry_cnt(mac_retry_cnt),
    .mac_one_coll(mac_one_coll), .mac_late_coll(mac_late_coll),
    .mac_underrun(mac_underrun), .mac_retry_limit(mac_retry_limit)
  );

  logic [31:0] mem [0:(1<<AW)-1];

  // reference expectations
  int unsigned xa_addr[$];
  bit          xa_we[$];
  logic [31:0] xa_data[$];
  string       xa_tag[$];
  bit          xa_mac[$];
  logic [12:0] xb[$];          // {final, first, last, pad, crc, data}
  logic [7:0]  xs[$];          // {retry_lim, underrun, late, one, retry[3:0]}
  logic [7:0]  plan_stats[$];

  int n_cmp = 0, n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;
  int rdy_mode = 0, lat_mode = 0;
  int rdy_ctr = 0, acc_ctr = 0, lat_left = 0, mac_cnt = 0;
  bit mac_given = 1'b0;
  bit stall_prev = 1'b0;
  logic [7:0] stall_data = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic push_acc(input int unsigned a, input bit we, input logic [31:0] d,
                          input string tag, input bit needmac);
    xa_addr.push_back(a); xa_we.push_back(we); xa_data.push_back(d);
    xa_tag.push_back(tag); xa_mac.push_back(needmac);
  endtask

  // behavioural walk of the descriptor chain in the current memory image
  task automatic model(input int unsigned d0);
    int unsigned d;
    bit first_desc;
    d = d0;
    first_desc = 1'b1;
    forever begin
      int unsigned w, bufa, a;
      int len;
      logic [31:0] cfg, wv, wb;
      logic [7:0] s;
      string rt;
      w    = d >> 2;
      cfg  = mem[w+5];
      bufa = mem[w];
      len  = int'(mem[w+4][15:0]);
      rt   = !cfg[31] ? "R3" : (first_desc ? "R2" : "R9");
      for (int k = 0; k < 6; k++) push_acc(w + k, 1'b0, '0, rt, 1'b0);
      if (!cfg[31]) break;
      for (int i = 0; i < len; i++) begin
        a = bufa + i;
        if (i == 0 || (a % 4) == 0) push_acc(a >> 2, 1'b0, '0, "R4", 1'b0);
        wv = mem[a >> 2];
        xb.push_back({(i == len - 1), (i == 0) && cfg[1], (i == len - 1) && cfg[0],
                      cfg[4], cfg[5], wv[8*(a%4) +: 8]});
      end
      if (len > 0) begin
        s = plan_stats.pop_front();
        xs.push_back(s);
      end else begin
        s = '0;
      end
      wb = '0;
      wb[15:0]  = cfg[15:0];
      wb[19:16] = s[3:0];
      wb[20]    = s[4];
      wb[24]    = s[5];
      wb[25]    = s[6];
      wb[26]    = s[7];
      wb[30]    = !(s[5] || s[6] || s[7]);
      push_acc(w + 5, 1'b1, wb, (len == 0) ? "R10" : "R7", len > 0);
      if (mem[w+3][31]) break;
      d = mem[w+2];
      first_desc = 1'b0;
    end
  endtask

  // all port activity on the far side of the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0; tx_ready = 1'b0; mac_stat_valid = 1'b0;
    end else begin
      if (stall_prev)
        chk(tx_valid && tx_data == stall_data, "R6", "held byte",
            {23'b0, tx_valid, tx_data}, {23'b0, 1'b1, stall_data});
      rdy_ctr++;
      case (rdy_mode)
        0:       tx_ready = 1'b1;
        1:       tx_ready = (rdy_ctr % 3) != 0;
        default: tx_ready = (rdy_ctr % 5) < 2;
      endcase
      stall_prev = tx_valid && !tx_ready;
      stall_data = tx_data;
      if (tx_valid && tx_ready) begin
        if (xb.size() == 0) begin
          chk(1'b0, "R4", "unexpected byte", {24'b0, tx_data}, '0);
        end else begin
          logic [12:0] e;
          e = xb.pop_front();
          chk({tx_first, tx_last, tx_pad, tx_crc, tx_data} == e[11:0], "R4/R5", "byte+flags",
              {20'b0, tx_first, tx_last, tx_pad, tx_crc, tx_data}, {20'b0, e[11:0]});
          if (e[12]) mac_cnt = 3;
        end
      end

      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req) begin
        if (lat_left > 0) begin
          lat_left--;
        end else begin
          if (xa_addr.size() == 0) begin
            chk(1'b0, "R3/R11", "unexpected access", {21'b0, mem_we, mem_addr}, '0);
          end else begin
            int unsigned ea;
            bit ewe, emac;
            logic [31:0] ed;
            string et;
            ea = xa_addr.pop_front(); ewe = xa_we.pop_front(); ed = xa_data.pop_front();
            et = xa_tag.pop_front();  emac = xa_mac.pop_front();
            chk(mem_addr == ea[AW-1:0] && mem_we == ewe, et, "access we/addr",
                {21'b0, mem_we, mem_addr}, {21'b0, ewe, ea[AW-1:0]});
            if (ewe) begin
              chk(mem_wdata == ed, et, "write-back word", mem_wdata, ed);
              if (emac) chk(mac_given, "R8", "write-back before MAC report", {31'b0, mac_given}, 32'd1);
              mac_given = 1'b0;
            end
          end
          if (mem_we) mem[mem_addr] = mem_wdata;
          else        mem_rdata = mem[mem_addr];
          mem_ack = 1'b1;
          acc_ctr++;
          lat_left = (lat_mode != 0) ? (acc_ctr % 4) : 0;
        end
      end

      if (mac_stat_valid) begin
        mac_stat_valid = 1'b0;
      end else if (mac_cnt > 0) begin
        mac_cnt--;
        if (mac_cnt == 0) begin
          logic [7:0] s;
          s = (xs.size() != 0) ? xs.pop_front() : 8'h00;
          {mac_retry_limit, mac_underrun, mac_late_coll, mac_one_coll, mac_retry_cnt} = s;
          mac_stat_valid = 1'b1;
          mac_given = 1'b1;
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic host_write(input bit sel, input logic [31:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_wr_sel = sel; host_wr_data = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic set_desc(input int unsigned d, input int unsigned bufa, input int unsigned nxt,
                          input bit last, input int len, input logic [31:0] cfg);
    int unsigned w;
    w = d >> 2;
    mem[w+0] = bufa;
    mem[w+1] = '0;
    mem[w+2] = nxt;
    mem[w+3] = {last, 31'b0};
    mem[w+4] = {16'hA5A5, len[15:0]};
    mem[w+5] = cfg;
    mem[w+6] = 32'h5EED_0006;
    mem[w+7] = 32'h5EED_0007;
  endtask

  task automatic drain(input string tag);
    int t;
    t = 0;
    while ((xa_addr.size() != 0 || xb.size() != 0) && t < 20000) begin
      @(negedge clk);
      t++;
    end
    repeat (40) @(negedge clk);
    chk(xa_addr.size() == 0 && xb.size() == 0, tag, "expected traffic left",
        xa_addr.size() + xb.size(), 0);
    chk(!mem_req && !tx_valid, tag, "quiet after chain", {30'b0, mem_req, tx_valid}, '0);
  endtask

  task automatic start(input int unsigned d);
    host_write(1'b0, d);
    host_write(1'b1, 32'h8000_0000);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = i * 32'h9E37_79B1 + 32'h0302_0100;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!mem_req && !tx_valid, "R1", "idle after reset", {30'b0, mem_req, tx_valid}, '0);
    end

    // R2: pointer-high write without bit 31 starts nothing
    set_desc(32'h080, 32'h400, 32'h0, 1'b1, 7, 32'h8000_0033);
    host_write(1'b0, 32'h080);
    host_write(1'b1, 32'h0000_0000);
    repeat (20) @(negedge clk);
    chk(!mem_req && !tx_valid, "R2", "no start without bit 31", {30'b0, mem_req, tx_valid}, '0);

    // single aligned frame, all flags, clean report
    plan_stats.push_back(8'h00);
    model(32'h080);
    start(32'h080);
    drain("R7");

    // unaligned buffer, backpressure, memory latency, late collision
    rdy_mode = 1; lat_mode = 1;
    set_desc(32'h0A0, 32'h503, 32'h0, 1'b1, 10, 32'h8000_0002);
    plan_stats.push_back(8'h20);
    model(32'h0A0);
    start(32'h0A0);
    drain("R4");

    // chain: unaligned frame -> zero length -> not owned; kick while busy
    rdy_mode = 2;
    set_desc(32'h0C0, 32'h601, 32'h0E0, 1'b0, 13, 32'h8000_0013);
    set_desc(32'h0E0, 32'h680, 32'h100, 1'b0, 0,  32'h8000_0003);
    set_desc(32'h100, 32'h690, 32'h0,   1'b1, 5,  32'h0000_0033);
    set_desc(32'h120, 32'h6A0, 32'h0,   1'b1, 3,  32'h8000_0033);
    plan_stats.push_back(8'h19);
    model(32'h0C0);
    start(32'h0C0);
    while (xb.size() > 6) @(negedge clk);
    start(32'h120);
    drain("R11");

    // owner clear on the first descriptor
    rdy_mode = 0; lat_mode = 0;
    set_desc(32'h140, 32'h6C0, 32'h0, 1'b1, 8, 32'h0000_0031);
    model(32'h140);
    start(32'h140);
    drain("R3");

    // underrun and retry limit, neither marker requested
    lat_mode = 1;
    set_desc(32'h160, 32'h700, 32'h0, 1'b1, 4, 32'h8000_0020);
    plan_stats.push_back(8'hC3);
    model(32'h160);
    start(32'h160);
    drain("R8");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule